// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Bit-Clock Source)

This block sends stereo PCM audio over a three-wire I2S link and produces both link clocks itself. It runs on a fast system clock that serves as the audio master clock. It divides that clock down to a bit clock and a word-select clock. It takes one left/right sample pair per frame through a valid/ready handshake and shifts each channel out most significant bit first, in two's complement, exactly as supplied.

The word-select line is low for the left channel and high for the right channel, with a 50% duty cycle at the sample rate. Serial data and word select change only on the falling edge of the bit clock, so a receiver samples them on the rising edge. Each word-select edge comes one bit period before the first bit of the new word. The last bit of every word therefore goes out in the first bit period after the edge.

A pair is taken only once per frame, at the moment the left word begins. If no pair is offered then, the previous pair is sent again. Until the first pair arrives the data line stays at zero.

Top module: `i2s_stereo_tx`

## Requirements
- R1: While `rstN` is low, `bitClk`, `wordSel`, `serData` and `inReady` are all 0.
- R2: `bitClk` has a period of CPB = MCLK_RATIO/(2·SAMPLE_W) system clocks (8 by default) and stays high and low for CPB/2 clocks each.
- R3: `serData` and `wordSel` change only in the same clock in which `bitClk` goes from 1 to 0.
- R4: `wordSel` toggles every SAMPLE_W bit-clock periods. A frame is 2·SAMPLE_W bit periods: the first SAMPLE_W have `wordSel`=0 and the rest have `wordSel`=1.
- R5: The left sample goes out MSB first. Its MSB is in the bit period right after `wordSel` falls, and its LSB is in the first bit period with `wordSel`=1.
- R6: The right sample goes out MSB first. Its MSB is in the bit period right after `wordSel` rises, and its LSB is in the first bit period after the following fall of `wordSel`.
- R7: `inReady` is high for exactly one system clock per frame: the clock just before the `bitClk` falling edge that launches the left MSB. A pair is taken when `inValid` is high in that clock.
- R8: If `inValid` is low in the `inReady` clock, the previously taken pair is sent again. Before any pair has been taken, both channels are sent as all zeros.
- R9: Values on `inValid`, `inLeft` and `inRight` outside the `inReady` clock have no effect on the transmitted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (audio master) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A stereo pair is offered |
| inLeft | input | SAMPLE_W | Left sample, two's complement |
| inRight | input | SAMPLE_W | Right sample, two's complement |
| inReady | output | 1 | Pair is taken in this clock if valid |
| bitClk | output | 1 | Serial bit clock |
| wordSel | output | 1 | Channel select: 0 left, 1 right |
| serData | output | 1 | Serial audio data, MSB first |

## Verification
A divider fault shows at the ports within one bit period, as a `bitClk` high or low run of the wrong length. A fault in the slot counter moves a `wordSel` edge or the `inReady` pulse, so it shows within one frame. An error in the holding register or the shift register has no timing signature. It shows only when the serial stream is decoded on rising bit-clock edges and compared word by word with the pairs offered, one frame after the pair was taken.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
  // Strobes from the sequencer to the datapath, one system clock wide.
  typedef struct packed {
    logic bitFall;   // bit clock goes low on the next edge
    logic loadPair;  // start of a left word: load a new or repeated pair
  } txStrobes_t;
endpackage

// File: rtl/i2s_tx_ctrl.sv
`timescale 1ns/1ps
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int MCLK_RATIO = 256
) (
  input  logic       clk,
  input  logic       rstN,
  output txStrobes_t strobes,
  output logic       bitClk,
  output logic       wordSel,
  output logic       inReady
);
  localparam int CLK_PER_BIT = MCLK_RATIO / (2 * SAMPLE_W);
  localparam int HALF_BIT    = CLK_PER_BIT / 2;
  localparam int SLOTS       = 2 * SAMPLE_W;
  localparam int DIV_W       = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
  localparam int SLOT_W      = $clog2(SLOTS);

  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] slotNext;
  logic              divLast;
  logic              divMid;
  logic              bitClkQ;
  logic              wordSelQ;

  assign divLast  = (divCnt == DIV_W'(CLK_PER_BIT - 1));
  assign divMid   = (divCnt == DIV_W'(HALF_BIT - 1));
  assign slotNext = (slotCnt == SLOT_W'(SLOTS - 1)) ? '0 : slotCnt + SLOT_W'(1);

  assign strobes.bitFall  = divLast;
  assign strobes.loadPair = divLast && (slotCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      slotCnt  <= '0;
      bitClkQ  <= 1'b0;
      wordSelQ <= 1'b0;
    end else begin
      divCnt <= divLast ? '0 : divCnt + DIV_W'(1);
      if (divMid) begin
        bitClkQ <= 1'b1;
      end
      if (divLast) begin
        bitClkQ  <= 1'b0;
        slotCnt  <= slotNext;
        wordSelQ <= (slotNext >= SLOT_W'(SAMPLE_W));
      end
    end
  end

  assign bitClk  = bitClkQ;
  assign wordSel = wordSelQ;
  assign inReady = strobes.loadPair;
endmodule

// File: rtl/i2s_tx_datapath.sv
`timescale 1ns/1ps
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobes_t          strobes,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                serData
);
  localparam int FRAME_W = 2 * SAMPLE_W;

  logic [SAMPLE_W-1:0] holdLeft;
  logic [SAMPLE_W-1:0] holdRight;
  logic [FRAME_W-1:0]  pairWord;
  logic [FRAME_W-1:0]  shiftReg;
  logic                serDataQ;
  logic                takeNew;

  assign takeNew  = strobes.loadPair && inValid;
  assign pairWord = inValid ? {inLeft, inRight} : {holdLeft, holdRight};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLeft  <= '0;
      holdRight <= '0;
    end else if (takeNew) begin
      holdLeft  <= inLeft;
      holdRight <= inRight;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      serDataQ <= 1'b0;
    end else if (strobes.loadPair) begin
      serDataQ <= pairWord[FRAME_W-1];
      shiftReg <= {pairWord[FRAME_W-2:0], 1'b0};
    end else if (strobes.bitFall) begin
      serDataQ <= shiftReg[FRAME_W-1];
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign serData = serDataQ;
endmodule

// File: rtl/i2s_stereo_tx.sv
`timescale 1ns/1ps
module i2s_stereo_tx
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int MCLK_RATIO = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                inReady,
  output logic                bitClk,
  output logic                wordSel,
  output logic                serData
);
  txStrobes_t strobes;

  i2s_tx_ctrl #(
    .SAMPLE_W  (SAMPLE_W),
    .MCLK_RATIO(MCLK_RATIO)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .bitClk (bitClk),
    .wordSel(wordSel),
    .inReady(inReady)
  );

  i2s_tx_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .inValid(inValid),
    .inLeft (inLeft),
    .inRight(inRight),
    .serData(serData)
  );
endmodule

// File: rtl/i2s_stereo_tx_chk.sv
`timescale 1ns/1ps
module i2s_stereo_tx_chk #(
  parameter int SAMPLE_W   = 16,
  parameter int MCLK_RATIO = 256
) (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic bitClk,
  input logic wordSel,
  input logic serData
);
  localparam int HALF_BIT = MCLK_RATIO / (4 * SAMPLE_W);

  logic prevB;
  logic wsPrev;
  int   runCnt;
  int   fallCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevB   <= 1'b0;
      wsPrev  <= 1'b0;
      runCnt  <= 0;
      fallCnt <= 0;
    end else begin
      prevB  <= bitClk;
      wsPrev <= wordSel;
      if (bitClk != prevB) runCnt <= 1;
      else                 runCnt <= runCnt + 1;
      if (wordSel != wsPrev)        fallCnt <= 0;
      else if (prevB && !bitClk)    fallCnt <= fallCnt + 1;
    end
  end

  assert_bclk_half_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bitClk != prevB) |-> (runCnt == HALF_BIT));

  assert_sd_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serData) |-> $fell(bitClk));

  assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordSel) |-> $fell(bitClk));

  assert_ws_period_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wordSel != wsPrev) |-> (fallCnt == SAMPLE_W - 1));

  assert_ready_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> $fell(bitClk));

  assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady);
endmodule

bind i2s_stereo_tx i2s_stereo_tx_chk #(
  .SAMPLE_W  (SAMPLE_W),
  .MCLK_RATIO(MCLK_RATIO)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inReady(inReady),
  .bitClk (bitClk),
  .wordSel(wordSel),
  .serData(serData)
);

// File: tb/i2s_stereo_tx_tb.sv
`timescale 1ns/1ps
module i2s_stereo_tx_tb;
  localparam int W     = 16;
  localparam int RATIO = 256;
  localparam int CPB   = RATIO / (2 * W);
  localparam int HALF  = CPB / 2;
  localparam int NV    = 8;
  localparam int NPAIR = NV + 2;

  // {valid, left, right}
  localparam logic [32:0] VECS [0:NV-1] = '{
    {1'b0, 16'h1111, 16'h2222},
    {1'b1, 16'h8001, 16'h7FFE},
    {1'b1, 16'hA5C3, 16'h0001},
    {1'b0, 16'h5555, 16'h6666},
    {1'b1, 16'hFFFF, 16'h0000},
    {1'b1, 16'h0000, 16'hFFFF},
    {1'b1, 16'h1234, 16'h8000},
    {1'b0, 16'h7777, 16'h9999}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] inLeft = '0;
  logic [W-1:0] inRight = '0;
  logic         inReady, bitClk, wordSel, serData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2s_stereo_tx #(.SAMPLE_W(W), .MCLK_RATIO(RATIO)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft),
    .inRight(inRight), .inReady(inReady), .bitClk(bitClk),
    .wordSel(wordSel), .serData(serData)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Receiver model: samples on rising bit clock, decodes by word-select change.
  logic [W-1:0] rxShift = '0;
  logic [W-1:0] gotLeft = '0;
  logic [W-1:0] rxL [0:NPAIR-1];
  logic [W-1:0] rxR [0:NPAIR-1];
  int  rxCount = 0;
  logic prevB = 0, prevSd = 0, prevWs = 0, lastBitWs = 0, pendReady = 0, seenRise = 0;
  int hiRun = 0, loRun = 0, risesSinceWs = 0, readyInFrame = 0;
  int viol2 = 0, viol3 = 0, viol4 = 0, viol7 = 0;

  always @(negedge clk) begin
    if (rstN) begin
      logic isRise, isFall;
      logic [W-1:0] word;
      isRise = bitClk && !prevB;
      isFall = !bitClk && prevB;
      if ((serData !== prevSd || wordSel !== prevWs) && !isFall) viol3++;   // R3
      if (isFall) begin
        if (hiRun != HALF) viol2++;                                          // R2
        hiRun = 0;
      end
      if (isRise) begin
        if (seenRise && loRun != HALF) viol2++;                              // R2
        loRun = 0;
        seenRise = 1;
      end
      if (bitClk) hiRun++; else loRun++;
      if (pendReady && !isFall) viol7++;                                     // R7
      pendReady = inReady;
      if (inReady) readyInFrame++;
      if (isRise) begin
        if (wordSel != lastBitWs) begin
          word = {rxShift[W-2:0], serData};
          if (risesSinceWs != W) viol4++;                                    // R4
          risesSinceWs = 1;
          if (wordSel) begin
            gotLeft = word;
            if (readyInFrame != 1) viol7++;                                  // R7
            readyInFrame = 0;
          end else if (rxCount < NPAIR) begin
            rxL[rxCount] = gotLeft;
            rxR[rxCount] = word;
            rxCount++;
          end
        end else begin
          risesSinceWs++;
        end
        rxShift = {rxShift[W-2:0], serData};
        lastBitWs = wordSel;
      end
      prevB = bitClk;
      prevSd = serData;
      prevWs = wordSel;
    end
  end

  task automatic waitReady();
    do @(negedge clk); while (!inReady);
    @(negedge clk);
  endtask

  logic [W-1:0] expL [0:NPAIR-1];
  logic [W-1:0] expR [0:NPAIR-1];

  initial begin
    logic [W-1:0] holdL, holdR;
    string tagL, tagR;
    holdL = '0;
    holdR = '0;
    // Reset with a pair offered: nothing may move (R1)
    inValid = 1'b1; inLeft = 16'hDEAD; inRight = 16'hBEEF;
    repeat (4) @(negedge clk);
    check("R1 bitClk", {31'd0, bitClk}, 32'd0);
    check("R1 wordSel", {31'd0, wordSel}, 32'd0);
    check("R1 serData", {31'd0, serData}, 32'd0);
    check("R1 inReady", {31'd0, inReady}, 32'd0);
    {inValid, inLeft, inRight} = VECS[0];
    rstN = 1'b1;

    // Table walk: each entry is offered across one whole frame
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][32]) begin holdL = VECS[i][31:16]; holdR = VECS[i][15:0]; end
      expL[i] = holdL;
      expR[i] = holdR;
      waitReady();
      if (i + 1 < NV) {inValid, inLeft, inRight} = VECS[i + 1];
      else begin inValid = 1'b0; inLeft = 16'h3C3C; inRight = 16'hC3C3; end
    end

    // R9: valid pulse with junk data away from the ready clock
    repeat (50) @(negedge clk);
    inValid = 1'b1; inLeft = 16'hDEAD; inRight = 16'hBEEF;
    repeat (100) @(negedge clk);
    inValid = 1'b0;
    expL[NV] = holdL;
    expR[NV] = holdR;
    waitReady();
    inValid = 1'b1; inLeft = 16'h0F0F; inRight = 16'hF0F0;
    expL[NV + 1] = 16'h0F0F;
    expR[NV + 1] = 16'hF0F0;
    waitReady();
    inValid = 1'b0;

    while (rxCount < NPAIR) @(negedge clk);

    for (int k = 0; k < NPAIR; k++) begin
      if (k == NV) begin tagL = "R9 left"; tagR = "R9 right"; end
      else if (k < NV && !VECS[k][32]) begin tagL = "R8 left"; tagR = "R8 right"; end
      else begin tagL = "R5 left"; tagR = "R6 right"; end
      check(tagL, {16'd0, rxL[k]}, {16'd0, expL[k]});
      check(tagR, {16'd0, rxR[k]}, {16'd0, expR[k]});
    end
    check("R2 bitClk run length", viol2, 0);
    check("R3 change off falling edge", viol3, 0);
    check("R4 wordSel period", viol4, 0);
    check("R7 ready placement", viol7, 0);
    check("R7 pairs seen", rxCount, NPAIR);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule